// File: doc/BRIEF.md
# Two-Step Multiply-Accumulate Unit with HI/LO Accumulator

This block keeps a 64-bit accumulator as two 32-bit halves, HI and LO. It takes commands, one at a time, over a valid/ready stream. Each command carries two operands and a 6-bit function code. The code selects whether the operand product is added to or subtracted from the accumulator, and whether the operands are treated as signed or unsigned. Each command runs in two steps. In the acceptance cycle the full 64-bit product is formed, its sign is corrected, it is negated for the subtract forms, and it is stored in an intermediate register. In the following cycle that value is added to {HI, LO}, and both halves are written together under a one-cycle write strobe.

A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. Operands are needed only in that cycle. The unit drops `cmd_ready` until its sequence has finished, so the sender must hold the command stable while `cmd_ready` is low. `busy_o` marks the accumulate step. `hold_i` is an external freeze. It blocks acceptance and stops the accumulate step. In the terminal step it keeps the unit parked, so a command that is held is never applied twice. Sums wrap modulo 2^64.

Top module: `mac_hilo`

## Requirements
- R1: A synchronous active-high reset clears HI, LO, the intermediate register and the step counter. After reset, `busy_o` and `hilo_we` are 0 and `cmd_ready` is 1.
- R2: Function code 6'b000000 (signed add) adds the two's-complement product of `cmd_a` and `cmd_b` to {HI, LO}.
- R3: Function code 6'b000001 (unsigned add) adds the unsigned product of `cmd_a` and `cmd_b` to {HI, LO}.
- R4: Function code 6'b000100 (signed subtract) subtracts the two's-complement product from {HI, LO}.
- R5: Function code 6'b000101 (unsigned subtract) subtracts the unsigned product from {HI, LO}.
- R6: After a command with a valid code is accepted on edge k, `busy_o` is 1 in the cycle that follows. Provided `hold_i` is low, HI/LO take their new value on edge k+1 and `hilo_we` is high for exactly that one cycle. HI and LO never change in any cycle where `hilo_we` is low.
- R7: `cmd_ready` is low from acceptance until the terminal step has been left. Provided `hold_i` stays low, the unit is ready again after edge k+2.
- R8: While `hold_i` is high in the terminal step, the unit stays in that step. It does not accumulate again, HI/LO stay unchanged, `hilo_we` stays low and `cmd_ready` stays low.
- R9: While `hold_i` is high during the accumulate step, `busy_o` stays high and no write happens. The accumulation takes place on the first edge where `hold_i` is low.
- R10: A command with any other function code is accepted and discarded. It leaves HI/LO unchanged and raises neither `busy_o` nor `hilo_we`.
- R11: The accumulation wraps modulo 2^64 and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_func | input | 6 | Operation code |
| cmd_a | input | 32 | First operand |
| cmd_b | input | 32 | Second operand |
| hold_i | input | 1 | External freeze request |
| busy_o | output | 1 | Accumulate step in progress (stall request) |
| hilo_we | output | 1 | One-cycle strobe marking a HI/LO write |
| hi_o | output | 32 | Upper accumulator half |
| lo_o | output | 32 | Lower accumulator half |

## Verification
When a command is accepted on edge k, three things follow on a fixed schedule. `busy_o` is high at the next falling edge. The written {HI, LO} and the `hilo_we` strobe appear one falling edge after that. `cmd_ready` comes back one falling edge later still. A hold stretches this schedule by exactly the number of held cycles. The driver pushes the accumulator value it computes from R2 to R5 into a queue. A monitor that samples on falling edges pops one entry each time `hilo_we` is seen and compares it. The driver checks the busy and ready timing at the falling edges where they are due, and counts the held cycles explicitly in the hold scenarios.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_ADD_S = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_ADD_U = 6'b000001;
  localparam logic [OPC_W-1:0] OPC_SUB_S = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_SUB_U = 6'b000101;

  // Step counter encoding; idle doubles as the product step.
  typedef enum logic [1:0] {
    STEP_PROD = 2'b00,
    STEP_ACC  = 2'b01,
    STEP_DONE = 2'b10
  } step_e;
endpackage

// File: rtl/mac_opdec.sv
`timescale 1ns/1ps
module mac_opdec
  import mac_pkg::*;
#(
  parameter int FUNC_W = OPC_W
) (
  input  logic [FUNC_W-1:0] func,
  output logic              known,
  output logic              is_signed,
  output logic              is_sub
);
  always_comb begin
    known     = 1'b1;
    is_signed = 1'b0;
    is_sub    = 1'b0;
    unique case (func)
      OPC_ADD_S: is_signed = 1'b1;
      OPC_ADD_U: ;
      OPC_SUB_S: begin is_signed = 1'b1; is_sub = 1'b1; end
      OPC_SUB_U: is_sub = 1'b1;
      default:   known = 1'b0;
    endcase
  end
endmodule

// File: rtl/mac_product.sv
`timescale 1ns/1ps
module mac_product #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           is_signed,
  input  logic           is_sub,
  output logic [2*W-1:0] term
);
  localparam int PW = 2 * W;

  logic [W-1:0]  mag_a, mag_b;
  logic [PW-1:0] raw, corrected;
  logic          flip;

  // Magnitudes: a negative signed operand is replaced by its complement.
  assign mag_a = (is_signed && a[W-1]) ? (~a + 1'b1) : a;
  assign mag_b = (is_signed && b[W-1]) ? (~b + 1'b1) : b;

  assign raw  = {{W{1'b0}}, mag_a} * {{W{1'b0}}, mag_b};
  assign flip = is_signed && (a[W-1] ^ b[W-1]);

  assign corrected = flip ? (~raw + 1'b1) : raw;
  assign term      = is_sub ? (~corrected + 1'b1) : corrected;
endmodule

// File: rtl/mac_seq.sv
`timescale 1ns/1ps
module mac_seq
  import mac_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic hold,
  output logic ready,
  output logic busy,
  output logic acc_en
);
  step_e step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= STEP_PROD;
    end else begin
      unique case (step_q)
        STEP_PROD: if (start) step_q <= STEP_ACC;
        STEP_ACC:  if (!hold) step_q <= STEP_DONE;
        STEP_DONE: if (!hold) step_q <= STEP_PROD;
        default:   step_q <= STEP_PROD;
      endcase
    end
  end

  assign ready  = (step_q == STEP_PROD) && !hold;
  assign busy   = (step_q == STEP_ACC);
  assign acc_en = (step_q == STEP_ACC) && !hold;
endmodule

// File: rtl/mac_hilo.sv
`timescale 1ns/1ps
module mac_hilo
  import mac_pkg::*;
#(
  parameter int W      = 32,
  parameter int FUNC_W = OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic [W-1:0]      cmd_a,
  input  logic [W-1:0]      cmd_b,
  input  logic              hold_i,
  output logic              busy_o,
  output logic              hilo_we,
  output logic [W-1:0]      hi_o,
  output logic [W-1:0]      lo_o
);
  localparam int AW = 2 * W;

  logic          op_known, op_signed, op_sub;
  logic          start, acc_en;
  logic [AW-1:0] term, stage_q, acc_q;

  mac_opdec #(.FUNC_W(FUNC_W)) u_dec (
    .func      (cmd_func),
    .known     (op_known),
    .is_signed (op_signed),
    .is_sub    (op_sub)
  );

  mac_product #(.W(W)) u_mul (
    .a         (cmd_a),
    .b         (cmd_b),
    .is_signed (op_signed),
    .is_sub    (op_sub),
    .term      (term)
  );

  assign start = cmd_valid && cmd_ready && op_known;

  mac_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .hold   (hold_i),
    .ready  (cmd_ready),
    .busy   (busy_o),
    .acc_en (acc_en)
  );

  // Intermediate term: loaded in the product step, cleared once consumed.
  always_ff @(posedge clk) begin
    if (rst)         stage_q <= '0;
    else if (start)  stage_q <= term;
    else if (acc_en) stage_q <= '0;
  end

  // Accumulator and write strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      hilo_we <= 1'b0;
    end else begin
      hilo_we <= acc_en;
      if (acc_en) acc_q <= acc_q + stage_q;
    end
  end

  assign hi_o = acc_q[AW-1:W];
  assign lo_o = acc_q[W-1:0];
endmodule

// File: rtl/mac_hilo_chk.sv
`timescale 1ns/1ps
module mac_hilo_chk #(
  parameter int W      = 32,
  parameter int FUNC_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [FUNC_W-1:0] cmd_func,
  input logic              hold_i,
  input logic              busy_o,
  input logic              hilo_we,
  input logic [W-1:0]      hi_o,
  input logic [W-1:0]      lo_o
);
  logic armed;
  logic taken_known, taken_other;

  always_ff @(posedge clk) armed <= !rst;

  assign taken_known = cmd_valid && cmd_ready &&
                       (cmd_func == 6'b000000 || cmd_func == 6'b000001 ||
                        cmd_func == 6'b000100 || cmd_func == 6'b000101);
  assign taken_other = cmd_valid && cmd_ready && !taken_known;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!busy_o && !hilo_we && hi_o == '0 && lo_o == '0));

  p_accept_busy_r6: assert property (@(posedge clk) disable iff (rst)
    taken_known |=> busy_o);

  p_acc_writes_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !hold_i) |=> (hilo_we && !busy_o));

  p_we_single_r6: assert property (@(posedge clk) disable iff (rst)
    hilo_we |=> !hilo_we);

  p_hilo_quiet_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    !hilo_we |-> (hi_o == $past(hi_o) && lo_o == $past(lo_o)));

  p_no_ready_busy_r7: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !cmd_ready);

  p_idle_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> !hilo_we);

  p_hold_freezes_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && hold_i) |=> (busy_o && !hilo_we));

  p_other_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    taken_other |=> !busy_o);
endmodule

bind mac_hilo mac_hilo_chk #(.W(W), .FUNC_W(FUNC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_func  (cmd_func),
  .hold_i    (hold_i),
  .busy_o    (busy_o),
  .hilo_we   (hilo_we),
  .hi_o      (hi_o),
  .lo_o      (lo_o)
);

// File: tb/tb_mac_hilo.sv
`timescale 1ns/1ps
module tb_mac_hilo;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [5:0]  cmd_func = '0;
  logic [31:0] cmd_a = '0, cmd_b = '0;
  logic        hold_i = 1'b0;
  logic        busy_o, hilo_we;
  logic [31:0] hi_o, lo_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [63:0] model = '0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  mac_hilo dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_func(cmd_func), .cmd_a(cmd_a), .cmd_b(cmd_b), .hold_i(hold_i),
    .busy_o(busy_o), .hilo_we(hilo_we), .hi_o(hi_o), .lo_o(lo_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Monitor: one scoreboard entry per write strobe.
  always @(negedge clk) begin
    if (!rst && hilo_we === 1'b1) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected write", 64'd1, 64'd0);
      end else begin
        check(tag_q.pop_front(), {hi_o, lo_o}, exp_q.pop_front());
      end
    end
  end

  // Driver: returns at the falling edge just after the accepting edge.
  task automatic send(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                      input string tag);
    logic signed [63:0] sa, sb;
    logic [63:0] p;
    bit known;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_func = f; cmd_a = a; cmd_b = b;
    while (cmd_ready !== 1'b1) @(negedge clk);
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    known = 1;
    case (f)
      6'b000000: p = sa * sb;
      6'b000001: p = {32'd0, a} * {32'd0, b};
      6'b000100: p = -(sa * sb);
      6'b000101: p = -({32'd0, a} * {32'd0, b});
      default:   begin p = '0; known = 0; end
    endcase
    if (known) begin
      model = model + p;
      exp_q.push_back(model);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Nominal schedule after a valid command with no hold.
  task automatic run(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                     input string tag);
    send(f, a, b, tag);
    check("R6 busy after accept", {63'd0, busy_o}, 64'd1);
    check("R7 not ready while busy", {63'd0, cmd_ready}, 64'd0);
    @(negedge clk);
    check("R6 write strobe due", {63'd0, hilo_we}, 64'd1);
    check("R7 not ready in terminal step", {63'd0, cmd_ready}, 64'd0);
    @(negedge clk);
    check("R7 ready again", {63'd0, cmd_ready}, 64'd1);
    check("R6 strobe one cycle", {63'd0, hilo_we}, 64'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    check("watchdog expired", 64'd1, 64'd0);
    finish_up();
  end

  initial begin
    logic [63:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 hi/lo after reset", {hi_o, lo_o}, 64'd0);
    check("R1 busy after reset", {63'd0, busy_o}, 64'd0);
    check("R1 strobe after reset", {63'd0, hilo_we}, 64'd0);
    check("R1 ready after reset", {63'd0, cmd_ready}, 64'd1);

    run(6'b000000, 32'd3, 32'hFFFF_FFFB, "R2 signed add 3*-5");
    run(6'b000000, 32'h8000_0000, 32'h8000_0000, "R2 signed add min*min");
    run(6'b000001, 32'hFFFF_FFFF, 32'd2, "R3 unsigned add");
    run(6'b000100, 32'hFFFF_FFF9, 32'hFFFF_FFF7, "R4 signed sub -7*-9");
    run(6'b000100, 32'd6, 32'hFFFF_FFFE, "R4 signed sub 6*-2");
    run(6'b000101, 32'h8000_0000, 32'h8000_0000, "R5 unsigned sub");
    // R11 wrap: repeated large unsigned adds pass 2^64
    for (int i = 0; i < 4; i++)
      run(6'b000001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R11 wrap on add");
    run(6'b000101, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R11 wrap on sub");

    // R10 unknown code ignored
    snap = {hi_o, lo_o};
    send(6'b000010, 32'd100, 32'd100, "R10");
    check("R10 no busy", {63'd0, busy_o}, 64'd0);
    repeat (2) begin
      @(negedge clk);
      check("R10 no strobe", {63'd0, hilo_we}, 64'd0);
      check("R10 hi/lo unchanged", {hi_o, lo_o}, snap);
    end
    check("R10 still ready", {63'd0, cmd_ready}, 64'd1);

    // R8 hold in terminal step
    send(6'b000000, 32'd11, 32'd13, "R8 held command result");
    @(negedge clk);
    hold_i = 1'b1;
    snap = model;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8 no repeat strobe", {63'd0, hilo_we}, 64'd0);
      check("R8 hi/lo stable", {hi_o, lo_o}, snap);
      check("R8 not ready while held", {63'd0, cmd_ready}, 64'd0);
    end
    hold_i = 1'b0;
    @(negedge clk);
    check("R8 ready after release", {63'd0, cmd_ready}, 64'd1);
    check("R8 single application", {hi_o, lo_o}, snap);

    // R9 hold in accumulate step
    send(6'b000001, 32'd1000, 32'd77, "R9 delayed accumulate");
    hold_i = 1'b1;
    snap = {hi_o, lo_o};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 busy held", {63'd0, busy_o}, 64'd1);
      check("R9 no strobe while held", {63'd0, hilo_we}, 64'd0);
      check("R9 hi/lo frozen", {hi_o, lo_o}, snap);
    end
    hold_i = 1'b0;
    @(negedge clk);
    check("R9 strobe after release", {63'd0, hilo_we}, 64'd1);
    repeat (3) @(negedge clk);
    check("R6 scoreboard drained", 64'(exp_q.size()), 64'd0);
    finish_up();
  end
endmodule